// File: doc/BRIEF.md
# Level-Shifted Multicarrier PWM Generator

This block produces the switching pattern for one leg of a nine-level inverter. The inverter has a level stage, which builds a voltage magnitude from four stacked sources, and a full bridge that only flips the sign at the fundamental rate. A phase accumulator steps through a sine wave. The sine is folded to its absolute value and scaled by a modulation index to give a unipolar reference. A second accumulator sets the carrier rate. From it, four carriers are built. Each carrier sits in its own quarter of the 12-bit range. The reference is compared against each one to give four level-select outputs.

The carrier waveform and the way the four bands are phased against each other are both chosen at run time, and so is the modulation index. A new choice is taken up only when the carrier phase wraps, so a carrier period never mixes two settings. A polarity flag and the four bridge gates follow the sign of the unfolded sine.

There are no data streams at this block's edge. Every input is a plain control level and every output is a registered level. No handshake is involved, and the block never applies back-pressure. A three-phase system uses three instances whose reference phases are 120 degrees apart.

Top module: `lsc_pwm_top`

## Requirements
- R1: While `rst_n` is low, `ref_o` and `level_o` are all zero, `pos_o` is 1 and `bridge_o` is 4'b1010. The carrier phase and the reference phase restart from zero, with triangle shape, all-in-phase mode and full index.
- R2: Each clock adds `ref_step_i` to the 24-bit reference phase. One cycle later, `ref_o` equals 4095·|sin(2π·phase/2^24)|·m/128, to within 24 counts, where m is the latched index.
- R3: The latched index is `mod_idx_i` limited to 128. Any value above 128 acts exactly like 128, and 0 gives a reference of zero.
- R4: Carrier k (k = 0..3) equals k·1024 + u_k, where u_k is in 0..1023. `level_o[k]` is 1 exactly when the reference is strictly greater than carrier k. Equality gives 0, and the levels therefore always form a thermometer code.
- R5: Let p be the top 11 bits of the 16-bit carrier phase. For `shape_i` = 0 or 3, the carrier is a triangle: u = p for p < 1024, otherwise 2047 − p. For `shape_i` = 1, it is a sawtooth: u = p/2. For `shape_i` = 2, it is a rectified sine: u ≈ 1023·sin(π·p/2048).
- R6: `mode_i` chooses which bands use 1023 − u instead of u. Code 0 inverts none. Code 1 inverts all four. Code 2 inverts bands 2 and 3. Code 3 inverts bands 1 and 3.
- R7: `pos_o` is 1 while the most significant bit of the reference phase that produced the current outputs is 0, and 0 otherwise.
- R8: `bridge_o` holds the gates {T4,T3,T2,T1}. A zero reference gives 4'b1010 (T2 with T4). Otherwise a positive sign gives 4'b0011 and a negative sign gives 4'b1100.
- R9: The shape, mode and index inputs are copied only on a clock where the 16-bit carrier phase plus `car_step_i` carries out. With `car_step_i` at zero, input changes have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_step_i | input | 24 | Reference phase increment per clock |
| car_step_i | input | 16 | Carrier phase increment per clock |
| shape_i | input | 2 | Carrier waveform select |
| mode_i | input | 2 | Band phasing select |
| mod_idx_i | input | 8 | Modulation index, 128 = unity |
| ref_o | output | 12 | Rectified, scaled reference |
| pos_o | output | 1 | Sign of the unfolded sine |
| level_o | output | 4 | Per-band level select |
| bridge_o | output | 4 | Bridge gates {T4,T3,T2,T1} |

## Verification
The comparison path is run with every pairing of the three waveforms and the four band phasings. Triangle and sawtooth have exact carrier values, so they pin down strict-greater versus equality and the bit each mode inverts. The sine carrier is checked only where the reference is clearly away from the carrier. Indices of 255, 90 and 0 separate clamping from plain scaling, and zero is the only way to hold the bridge in its zero state. A frozen carrier phase with changed inputs shows whether settings leak in before a wrap. Random steps, with settings changed in the middle of a period, then mix all of these.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  typedef enum logic [1:0] {SHP_TRI = 2'd0, SHP_SAW = 2'd1, SHP_RSIN = 2'd2, SHP_TRI2 = 2'd3} shape_e;
  typedef enum logic [1:0] {DSP_PD = 2'd0, DSP_IPD = 2'd1, DSP_POD = 2'd2, DSP_APOD = 2'd3} mode_e;

  localparam logic [3:0] BR_POS  = 4'b0011;
  localparam logic [3:0] BR_NEG  = 4'b1100;
  localparam logic [3:0] BR_ZERO = 4'b1010;

  // Does band k of nb use the inverted carrier under mode m?
  function automatic logic band_inverted(input mode_e m, input int k, input int nb);
    case (m)
      DSP_PD:  return 1'b0;
      DSP_IPD: return 1'b1;
      DSP_POD: return (k >= nb / 2);
      default: return k[0];
    endcase
  endfunction
endpackage

// File: rtl/lsc_sine_approx.sv
// Rational approximation of sin over a quarter wave:
// sin ~ 4p/(5N^2 - p), with p = x(2N - x), where x = N means 90 degrees.
module lsc_sine_approx #(
  parameter int IW = 10,
  parameter int OW = 12
) (
  input  logic [IW:0]   x_i,
  output logic [OW-1:0] y_o
);
  localparam int NQ = 1 << IW;
  localparam int PW = 2 * IW + 3;
  localparam int NW = PW + OW + 2;
  localparam logic [PW-1:0] DEN0 = PW'(5 * (1 << (2 * IW)));

  logic [PW-1:0] prod, den;
  logic [NW-1:0] num;

  always_comb begin
    prod = PW'(x_i) * (PW'(2 * NQ) - PW'(x_i));
    den  = DEN0 - prod;
    num  = NW'((1 << OW) - 1) * NW'(prod) * NW'(4);
    y_o  = OW'(num / NW'(den));
  end
endmodule

// File: rtl/lsc_ref_gen.sv
// Folds the reference phase into a rectified sine and applies the index.
module lsc_ref_gen #(
  parameter int DW = 12,
  parameter int QW = 10,
  parameter int MW = 8
) (
  input  logic [QW+1:0] ph_i,
  input  logic [MW-1:0] midx_i,
  output logic [DW-1:0] ref_o,
  output logic          pos_o
);
  localparam int XW = QW + 1;
  localparam int SW = DW + MW;

  logic [XW-1:0] x;
  logic [DW-1:0] mag;
  logic [SW-1:0] scaled;

  always_comb begin
    x = ph_i[QW] ? ((XW'(1) << QW) - {1'b0, ph_i[QW-1:0]}) : {1'b0, ph_i[QW-1:0]};
    scaled = SW'(mag) * SW'(midx_i);
    ref_o  = DW'(scaled >> (MW - 1));
  end

  assign pos_o = ~ph_i[QW+1];

  lsc_sine_approx #(.IW(QW), .OW(DW)) u_sin (.x_i(x), .y_o(mag));
endmodule

// File: rtl/lsc_carrier_bank.sv
// Builds one base carrier waveform and compares the reference with each stacked band.
module lsc_carrier_bank
  import lsc_pkg::*;
#(
  parameter int NB = 4,
  parameter int BW = 10
) (
  input  logic [BW:0]       ph_i,
  input  shape_e            shape_i,
  input  mode_e             mode_i,
  input  logic [BW+$clog2(NB)-1:0] ref_i,
  output logic [NB-1:0]     lvl_o
);
  localparam int LB = $clog2(NB);
  localparam int XW = BW + 1;

  logic [BW-1:0] tri_u, sin_u, u;
  logic [XW-1:0] sx;

  always_comb begin
    tri_u = ph_i[BW] ? ~ph_i[BW-1:0] : ph_i[BW-1:0];
    sx    = ph_i[BW] ? ((XW'(1) << BW) - {1'b0, ph_i[BW-1:0]}) : {1'b0, ph_i[BW-1:0]};
    case (shape_i)
      SHP_SAW:  u = ph_i[BW:1];
      SHP_RSIN: u = sin_u;
      default:  u = tri_u;
    endcase
  end

  lsc_sine_approx #(.IW(BW), .OW(BW)) u_csin (.x_i(sx), .y_o(sin_u));

  for (genvar k = 0; k < NB; k++) begin : g_band
    logic          inv;
    logic [BW-1:0] uk;
    assign inv      = band_inverted(mode_i, k, NB);
    assign uk       = inv ? ~u : u;
    assign lvl_o[k] = ref_i > {LB'(k), uk};
  end
endmodule

// File: rtl/lsc_pwm_top.sv
module lsc_pwm_top
  import lsc_pkg::*;
#(
  parameter int DW  = 12,
  parameter int NB  = 4,
  parameter int RPW = 24,
  parameter int CPW = 16,
  parameter int MW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [RPW-1:0] ref_step_i,
  input  logic [CPW-1:0] car_step_i,
  input  logic [1:0]     shape_i,
  input  logic [1:0]     mode_i,
  input  logic [MW-1:0]  mod_idx_i,
  output logic [DW-1:0]  ref_o,
  output logic           pos_o,
  output logic [NB-1:0]  level_o,
  output logic [3:0]     bridge_o
);
  localparam int LB    = $clog2(NB);
  localparam int BW    = DW - LB;
  localparam int QW    = DW - 2;
  localparam int MFULL = 1 << (MW - 1);

  logic [RPW-1:0] rph_q;
  logic [CPW-1:0] cph_q;
  logic [CPW:0]   csum;
  logic           wrap;
  shape_e         shape_q;
  mode_e          mode_q;
  logic [MW-1:0]  midx_q;

  logic [DW-1:0]  ref_c;
  logic           pos_c;
  logic [NB-1:0]  lvl_c;

  assign csum = {1'b0, cph_q} + {1'b0, car_step_i};
  assign wrap = csum[CPW];

  // Phase accumulators and configuration taken only at a carrier wrap
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rph_q   <= '0;
      cph_q   <= '0;
      shape_q <= SHP_TRI;
      mode_q  <= DSP_PD;
      midx_q  <= MW'(MFULL);
    end else begin
      rph_q <= rph_q + ref_step_i;
      cph_q <= csum[CPW-1:0];
      if (wrap) begin
        shape_q <= shape_e'(shape_i);
        mode_q  <= mode_e'(mode_i);
        midx_q  <= (mod_idx_i > MW'(MFULL)) ? MW'(MFULL) : mod_idx_i;
      end
    end
  end

  lsc_ref_gen #(.DW(DW), .QW(QW), .MW(MW)) u_ref (
    .ph_i   (rph_q[RPW-1 -: QW+2]),
    .midx_i (midx_q),
    .ref_o  (ref_c),
    .pos_o  (pos_c)
  );

  lsc_carrier_bank #(.NB(NB), .BW(BW)) u_bank (
    .ph_i    (cph_q[CPW-1 -: BW+1]),
    .shape_i (shape_q),
    .mode_i  (mode_q),
    .ref_i   (ref_c),
    .lvl_o   (lvl_c)
  );

  // Registered outputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_o    <= '0;
      pos_o    <= 1'b1;
      level_o  <= '0;
      bridge_o <= BR_ZERO;
    end else begin
      ref_o    <= ref_c;
      pos_o    <= pos_c;
      level_o  <= lvl_c;
      bridge_o <= (ref_c == '0) ? BR_ZERO : (pos_c ? BR_POS : BR_NEG);
    end
  end
endmodule

// File: rtl/lsc_pwm_chk.sv
module lsc_pwm_chk #(
  parameter int DW = 12,
  parameter int NB = 4,
  parameter int MW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] ref_o,
  input logic          pos_o,
  input logic [NB-1:0] level_o,
  input logic [3:0]    bridge_o,
  input logic          wrap,
  input logic [1:0]    shape_q,
  input logic [1:0]    mode_q,
  input logic [MW-1:0] midx_q
);
  localparam int BAND  = (1 << DW) / NB;
  localparam int MFULL = 1 << (MW - 1);

  for (genvar k = 0; k < NB; k++) begin : g_lvl
    assert_level_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
      level_o[k] |-> (int'(ref_o) > k * BAND));
    assert_level_ceiling_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(ref_o) >= (k + 1) * BAND) |-> level_o[k]);
    if (k + 1 < NB) begin : g_th
      assert_level_thermo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        level_o[k+1] |-> level_o[k]);
    end
  end

  assert_bridge_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_o == '0) |-> (bridge_o == 4'b1010));
  assert_bridge_sign_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_o != '0) |-> (bridge_o == (pos_o ? 4'b0011 : 4'b1100)));
  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(shape_q) && $stable(mode_q) && $stable(midx_q)));
  assert_idx_clamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(midx_q) <= MFULL);
  assert_zero_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (midx_q == '0) |=> (ref_o == '0));
endmodule

bind lsc_pwm_top lsc_pwm_chk #(.DW(DW), .NB(NB), .MW(MW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ref_o    (ref_o),
  .pos_o    (pos_o),
  .level_o  (level_o),
  .bridge_o (bridge_o),
  .wrap     (wrap),
  .shape_q  (shape_q),
  .mode_q   (mode_q),
  .midx_q   (midx_q)
);

// File: tb/sim_lsc_pwm_top.sv
module sim_lsc_pwm_top;
  localparam int DW = 12, NB = 4, RPW = 24, CPW = 16, MW = 8;
  localparam int BAND = 1024, MFULL = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [RPW-1:0] ref_step = '0;
  logic [CPW-1:0] car_step = '0;
  logic [1:0] shape = 2'd0, mode = 2'd0;
  logic [MW-1:0] midx = 8'd128;
  logic [DW-1:0] ref_o;
  logic pos_o;
  logic [NB-1:0] level_o;
  logic [3:0] bridge_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  string tag = "R1";

  // Bench model state
  logic [RPW-1:0] m_rph = '0;
  logic [CPW-1:0] m_cph = '0;
  int m_shape = 0, m_mode = 0, m_m = MFULL;

  always #2 clk = ~clk;

  lsc_pwm_top u0 (
    .clk(clk), .rst_n(rst_n), .ref_step_i(ref_step), .car_step_i(car_step),
    .shape_i(shape), .mode_i(mode), .mod_idx_i(midx),
    .ref_o(ref_o), .pos_o(pos_o), .level_o(level_o), .bridge_o(bridge_o)
  );

  task automatic check(string rq, bit ok, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s [%s]: actual %0d expected %0d", rq, tag, act, exp);
    end
  endtask

  function automatic bit inv_band(int md, int k);
    case (md)
      0: return 1'b0;
      1: return 1'b1;
      2: return k >= NB / 2;
      default: return (k % 2) == 1;
    endcase
  endfunction

  task automatic verify(logic [RPW-1:0] s_rph, logic [CPW-1:0] s_cph, int s_shape, int s_mode, int s_m);
    real e, d, ur, car;
    bit  pos, expb;
    logic [3:0] exp_br;
    int p, u, ci;
    e = 4095.0 * $sin(6.283185307179586 * real'(s_rph) / 16777216.0) * real'(s_m) / 128.0;
    if (e < 0.0) e = -e;
    d = real'(ref_o) - e;
    if (d < 0.0) d = -d;
    check("R2", d <= 24.0, int'(ref_o), int'(e));
    pos = ~s_rph[RPW-1];
    check("R7", pos_o == pos, int'(pos_o), int'(pos));
    exp_br = (ref_o == '0) ? 4'b1010 : (pos ? 4'b0011 : 4'b1100);
    check("R8", bridge_o == exp_br, int'(bridge_o), int'(exp_br));
    p = int'(s_cph >> (CPW - 11));
    for (int k = 0; k < NB; k++) begin
      if (s_shape == 2) begin
        ur  = 1023.0 * $sin(3.141592653589793 * real'(p) / 2048.0);
        car = real'(k * BAND) + (inv_band(s_mode, k) ? 1023.0 - ur : ur);
        d = real'(ref_o) - car;
        if (d > 6.0 || d < -6.0) begin
          expb = real'(ref_o) > car;
          check("R4 R5 R6", level_o[k] == expb, int'(level_o[k]), int'(expb));
        end
      end else begin
        u  = (s_shape == 1) ? p / 2 : ((p >= 1024) ? 2047 - p : p);
        ci = k * BAND + (inv_band(s_mode, k) ? 1023 - u : u);
        expb = int'(ref_o) > ci;
        check("R4 R5 R6", level_o[k] == expb, int'(level_o[k]), int'(expb));
      end
    end
  endtask

  task automatic tick();
    logic [RPW-1:0] s_rph;
    logic [CPW-1:0] s_cph;
    logic [CPW:0] sum;
    int s_shape, s_mode, s_m;
    @(posedge clk);
    s_rph = m_rph; s_cph = m_cph; s_shape = m_shape; s_mode = m_mode; s_m = m_m;
    sum   = {1'b0, m_cph} + {1'b0, car_step};
    m_cph = sum[CPW-1:0];
    m_rph = m_rph + ref_step;
    if (sum[CPW]) begin
      m_shape = int'(shape);
      m_mode  = int'(mode);
      m_m     = (int'(midx) > MFULL) ? MFULL : int'(midx);
    end
    #1;
    verify(s_rph, s_cph, s_shape, s_mode, s_m);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    ref_step = 24'd8389; car_step = 16'd1311;
    // R1: reset state while held
    repeat (4) @(posedge clk);
    #1;
    check("R1", ref_o == '0, int'(ref_o), 0);
    check("R1", level_o == '0, int'(level_o), 0);
    check("R1", pos_o == 1'b1, int'(pos_o), 1);
    check("R1", bridge_o == 4'b1010, int'(bridge_o), 10);
    rst_n = 1'b1;

    tag = "R2 R4 triangle in phase";
    run(2100);

    for (int sh = 0; sh < 4; sh++)
      for (int md = 0; md < 4; md++) begin
        tag = $sformatf("R5 R6 shape %0d mode %0d", sh, md);
        shape = 2'(sh); mode = 2'(md);
        run(500);
      end

    tag = "R3 clamp 255"; shape = 2'd0; mode = 2'd0; midx = 8'd255;
    run(2100);
    tag = "R3 index 90"; midx = 8'd90;
    run(800);

    tag = "R9 frozen carrier";
    car_step = 16'd0;
    run(5);
    shape = 2'd2; mode = 2'd3; midx = 8'd0;
    run(400);
    tag = "R9 resume"; car_step = 16'd1311;
    run(400);

    tag = "R8 zero index"; midx = 8'd0;
    run(300);

    for (int s = 0; s < 25; s++) begin
      int len;
      tag = $sformatf("random %0d", s);
      ref_step = 24'(2000 + $urandom % 30000);
      car_step = 16'(200 + $urandom % 6000);
      shape = 2'($urandom % 4); mode = 2'($urandom % 4);
      midx = 8'($urandom % 256);
      len = 400 + int'($urandom % 1200);
      run(len / 2);
      mode = 2'($urandom % 4); shape = 2'($urandom % 4);
      run(len - len / 2);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule